// File: doc/BRIEF.md
# Stimulus Sequencing Processor Core

This block is a small register-based processor built to produce test stimuli on chip. Its arithmetic unit does the work of a pattern generator, so short programs can drive accumulator-style sequences, counters, rotating masks and carry-chained sums without a dedicated generator circuit. Each cycle it fetches one 16-bit instruction from a read-only program memory, executes it, and moves on. The instruction set is deliberately narrow. It has loads, a register copy, add with and without carry, the three bitwise operations, invert, rotate left, a compare against a constant, and one conditional branch that serves as the loop primitive.

Patterns leave the core through register 7. Every write to that register also appears on a dedicated output bus, together with a strobe that lasts one cycle. A data memory read port feeds the memory-load instruction. Both memory ports are modelled as combinational reads, so every instruction, including a memory load, completes in a single cycle.

Top module: `tpp_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter, all eight 8-bit registers, the carry flag and the equal flag to zero. It also drives the pattern bus to zero and the strobe low.
- R2: Opcode 1 (memory load) writes Rd with the data memory word at address k, and `dmem_addr` shows k. Opcode 2 (immediate load) writes k into Rd.
- R3: Opcode 3 (move) copies Rr into Rd and leaves Rr unchanged.
- R4: Opcodes 4 (add register) and 5 (add immediate) write the 8-bit sum to Rd and set carry to the carry out of bit 7. Opcodes 6 and 7 do the same and also add the current carry. No other instruction changes carry.
- R5: Opcodes 8/9 (AND register/immediate), 10/11 (OR register/immediate) and 12 (XOR register) combine Rd bitwise with the operand and write the result to Rd.
- R6: Opcode 13 inverts every bit of Rd. Opcode 14 rotates Rd left by one, with bit 7 moving to bit 0 and carry neither used nor changed.
- R7: Opcode 15 sets the equal flag when Rd equals k and clears it otherwise. It writes no register and leaves carry unchanged.
- R8: Opcode 16 loads the program counter with k when the equal flag is clear. Otherwise the next address is the current one plus one.
- R9: An instruction word is laid out as opcode [15:11], Rd [10:8], Rr [7:5] and k [7:0]. Opcodes 0 and 17 to 31 do nothing except advance the program counter. The 8-bit program counter wraps from 255 to 0.
- R10: A write to register 7 puts the written value on `pat_data` and raises `pat_valid` for one cycle, both on the edge that performs the write. `pat_data` holds its value until the next such write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Program memory address (program counter) |
| imem_data | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 8 | Data memory read address (the k field) |
| dmem_data | input | 8 | Data word at `dmem_addr` |
| pat_data | output | 8 | Last value written to register 7 |
| pat_valid | output | 1 | One-cycle strobe marking a register-7 write |

## Verification
The assertions assume that both memories answer combinationally and that `imem_data` and `dmem_data` never carry unknown bits once reset is released. The properties on the program counter and the flags rely on the decoded fields of a fully defined word. The bench meets these assumptions by modelling both memories as fully initialised arrays that are indexed directly by the address outputs. It generates random programs with opcodes drawn from the whole 5-bit space and keeps branch targets inside the program area, so loops stay bounded while undefined opcodes and counter wrap still occur.

// File: rtl/tpp_pkg.sv
package tpp_pkg;

    localparam int DATA_W  = 8;
    localparam int NREG    = 8;
    localparam int INSTR_W = 16;
    localparam int OPC_W   = 5;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int PC_W    = DATA_W;
    localparam int PAT_REG = NREG - 1;

    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RD_LSB  = OPC_LSB - RIDX_W;
    localparam int RR_LSB  = DATA_W - RIDX_W;

    localparam logic [OPC_W-1:0] OPC_NOP  = 5'd0;
    localparam logic [OPC_W-1:0] OPC_LDM  = 5'd1;
    localparam logic [OPC_W-1:0] OPC_LDI  = 5'd2;
    localparam logic [OPC_W-1:0] OPC_MOV  = 5'd3;
    localparam logic [OPC_W-1:0] OPC_ADD  = 5'd4;
    localparam logic [OPC_W-1:0] OPC_ADDI = 5'd5;
    localparam logic [OPC_W-1:0] OPC_ADC  = 5'd6;
    localparam logic [OPC_W-1:0] OPC_ADCI = 5'd7;
    localparam logic [OPC_W-1:0] OPC_AND  = 5'd8;
    localparam logic [OPC_W-1:0] OPC_ANDI = 5'd9;
    localparam logic [OPC_W-1:0] OPC_OR   = 5'd10;
    localparam logic [OPC_W-1:0] OPC_ORI  = 5'd11;
    localparam logic [OPC_W-1:0] OPC_XOR  = 5'd12;
    localparam logic [OPC_W-1:0] OPC_INV  = 5'd13;
    localparam logic [OPC_W-1:0] OPC_ROL  = 5'd14;
    localparam logic [OPC_W-1:0] OPC_CMPI = 5'd15;
    localparam logic [OPC_W-1:0] OPC_BNE  = 5'd16;

    typedef enum logic [2:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_INV,
        ALU_ROL
    } alu_fn_e;

    typedef enum logic [1:0] {
        SRC_REG,
        SRC_IMM,
        SRC_MEM
    } src_sel_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rr;
        logic [DATA_W-1:0] imm;
        logic              wr_en;
        src_sel_e          src;
        alu_fn_e           fn;
        logic              use_cy;
        logic              upd_cy;
        logic              is_cmp;
        logic              is_bne;
    } dec_t;

    function automatic logic [OPC_W-1:0] opc_of(input logic [INSTR_W-1:0] w);
        return w[OPC_LSB +: OPC_W];
    endfunction

    function automatic logic [RIDX_W-1:0] rd_of(input logic [INSTR_W-1:0] w);
        return w[RD_LSB +: RIDX_W];
    endfunction

    function automatic logic [RIDX_W-1:0] rr_of(input logic [INSTR_W-1:0] w);
        return w[RR_LSB +: RIDX_W];
    endfunction

endpackage

// File: rtl/tpp_decode.sv
module tpp_decode
    import tpp_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);

    always_comb begin
        dec        = '0;
        dec.opc    = opc_of(instr);
        dec.rd     = rd_of(instr);
        dec.rr     = rr_of(instr);
        dec.imm    = instr[DATA_W-1:0];
        dec.src    = SRC_REG;
        dec.fn     = ALU_PASS;
        unique case (dec.opc)
            OPC_LDM:  begin dec.wr_en = 1'b1; dec.src = SRC_MEM; end
            OPC_LDI:  begin dec.wr_en = 1'b1; dec.src = SRC_IMM; end
            OPC_MOV:  begin dec.wr_en = 1'b1; end
            OPC_ADD:  begin dec.wr_en = 1'b1; dec.fn = ALU_ADD; dec.upd_cy = 1'b1; end
            OPC_ADDI: begin dec.wr_en = 1'b1; dec.fn = ALU_ADD; dec.upd_cy = 1'b1;
                            dec.src = SRC_IMM; end
            OPC_ADC:  begin dec.wr_en = 1'b1; dec.fn = ALU_ADD; dec.upd_cy = 1'b1;
                            dec.use_cy = 1'b1; end
            OPC_ADCI: begin dec.wr_en = 1'b1; dec.fn = ALU_ADD; dec.upd_cy = 1'b1;
                            dec.use_cy = 1'b1; dec.src = SRC_IMM; end
            OPC_AND:  begin dec.wr_en = 1'b1; dec.fn = ALU_AND; end
            OPC_ANDI: begin dec.wr_en = 1'b1; dec.fn = ALU_AND; dec.src = SRC_IMM; end
            OPC_OR:   begin dec.wr_en = 1'b1; dec.fn = ALU_OR; end
            OPC_ORI:  begin dec.wr_en = 1'b1; dec.fn = ALU_OR; dec.src = SRC_IMM; end
            OPC_XOR:  begin dec.wr_en = 1'b1; dec.fn = ALU_XOR; end
            OPC_INV:  begin dec.wr_en = 1'b1; dec.fn = ALU_INV; end
            OPC_ROL:  begin dec.wr_en = 1'b1; dec.fn = ALU_ROL; end
            OPC_CMPI: begin dec.is_cmp = 1'b1; dec.src = SRC_IMM; end
            OPC_BNE:  begin dec.is_bne = 1'b1; end
            default:  begin end
        endcase
    end

endmodule

// File: rtl/tpp_regfile.sv
module tpp_regfile #(
    parameter int N = 8,
    parameter int W = 8,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_a,
    output logic [W-1:0]  rdata_b
);

    logic [N-1:0][W-1:0] regs_q;

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (we && waddr == AW'(i)) begin
                regs_q[i] <= wdata;
            end
        end
    end

    assign rdata_a = regs_q[raddr_a];
    assign rdata_b = regs_q[raddr_b];

endmodule

// File: rtl/tpp_alu.sv
module tpp_alu
    import tpp_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);

    logic [W:0] sum;

    assign sum = {1'b0, a} + {1'b0, b} + (W+1)'(cin);

    always_comb begin
        res  = b;
        cout = 1'b0;
        unique case (fn)
            ALU_PASS: res = b;
            ALU_ADD:  begin res = sum[W-1:0]; cout = sum[W]; end
            ALU_AND:  res = a & b;
            ALU_OR:   res = a | b;
            ALU_XOR:  res = a ^ b;
            ALU_INV:  res = ~a;
            ALU_ROL:  res = {a[W-2:0], a[W-1]};
            default:  res = b;
        endcase
    end

endmodule

// File: rtl/tpp_core.sv
module tpp_core
    import tpp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [DATA_W-1:0]  dmem_addr,
    input  logic [DATA_W-1:0]  dmem_data,
    output logic [DATA_W-1:0]  pat_data,
    output logic               pat_valid
);

    dec_t              dec;
    logic [PC_W-1:0]   pc_q;
    logic              cy_q;
    logic              eq_q;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rr_val;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] wr_data;
    logic              alu_cout;
    logic              wr_en;
    logic [RIDX_W-1:0] wr_idx;
    logic              take_br;

    tpp_decode u_dec (
        .instr (imem_data),
        .dec   (dec)
    );

    tpp_regfile #(.N(NREG), .W(DATA_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_en),
        .waddr   (wr_idx),
        .wdata   (wr_data),
        .raddr_a (dec.rd),
        .raddr_b (dec.rr),
        .rdata_a (rd_val),
        .rdata_b (rr_val)
    );

    always_comb begin
        unique case (dec.src)
            SRC_IMM: opnd_b = dec.imm;
            SRC_MEM: opnd_b = dmem_data;
            default: opnd_b = rr_val;
        endcase
    end

    tpp_alu #(.W(DATA_W)) u_alu (
        .fn   (dec.fn),
        .a    (rd_val),
        .b    (opnd_b),
        .cin  (dec.use_cy & cy_q),
        .res  (wr_data),
        .cout (alu_cout)
    );

    assign wr_en     = dec.wr_en;
    assign wr_idx    = dec.rd;
    assign take_br   = dec.is_bne & ~eq_q;
    assign imem_addr = pc_q;
    assign dmem_addr = dec.imm;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            cy_q <= 1'b0;
            eq_q <= 1'b0;
        end else begin
            pc_q <= take_br ? PC_W'(dec.imm) : pc_q + PC_W'(1);
            if (dec.upd_cy) cy_q <= alu_cout;
            if (dec.is_cmp) eq_q <= (rd_val == dec.imm);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_data  <= '0;
            pat_valid <= 1'b0;
        end else begin
            pat_valid <= wr_en && (wr_idx == RIDX_W'(PAT_REG));
            if (wr_en && (wr_idx == RIDX_W'(PAT_REG))) pat_data <= wr_data;
        end
    end

endmodule

// File: rtl/tpp_checker.sv
module tpp_checker
    import tpp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [PC_W-1:0]   imem_addr,
    input logic [DATA_W-1:0] pat_data,
    input logic              pat_valid,
    input dec_t              dec,
    input logic              cy_q,
    input logic              eq_q,
    input logic              wr_en,
    input logic [RIDX_W-1:0] wr_idx,
    input logic [DATA_W-1:0] wr_data
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (imem_addr == '0 && !pat_valid && pat_data == '0 && !cy_q && !eq_q));

    assert_carry_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !dec.upd_cy |=> $stable(cy_q));

    assert_cmp_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (dec.opc == OPC_CMPI) |-> !wr_en);

    assert_branch_taken_R8: assert property (@(posedge clk) disable iff (rst)
        (dec.opc == OPC_BNE && !eq_q) |=> imem_addr == $past(dec.imm));

    assert_pc_step_R9: assert property (@(posedge clk) disable iff (rst)
        !(dec.opc == OPC_BNE && !eq_q) |=> imem_addr == $past(imem_addr) + PC_W'(1));

    assert_pattern_strobe_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == RIDX_W'(PAT_REG)) |=> (pat_valid && pat_data == $past(wr_data)));

    assert_pattern_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_idx == RIDX_W'(PAT_REG)) |=> (!pat_valid && $stable(pat_data)));

endmodule

bind tpp_core tpp_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .pat_data  (pat_data),
    .pat_valid (pat_valid),
    .dec       (dec),
    .cy_q      (cy_q),
    .eq_q      (eq_q),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
);

// File: tb/tpp_core_tb.sv
module tpp_core_tb_top;

    localparam time CLK_P = 8ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr;
    logic [15:0] imem_data;
    logic [7:0]  dmem_addr;
    logic [7:0]  dmem_data;
    logic [7:0]  pat_data;
    logic        pat_valid;

    logic [15:0] prog [256];
    logic [7:0]  dmem [256];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] m_reg [8];
    logic       m_cy, m_eq, m_pv;
    logic [7:0] m_pc, m_pd;

    always #(CLK_P/2) clk = ~clk;

    assign imem_data = prog[imem_addr];
    assign dmem_data = dmem[dmem_addr];

    tpp_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .dmem_addr (dmem_addr),
        .dmem_data (dmem_data),
        .pat_data  (pat_data),
        .pat_valid (pat_valid)
    );

    function automatic logic [15:0] enc_r(int op, int rd, int rr);
        return {op[4:0], rd[2:0], rr[2:0], 5'b0};
    endfunction

    function automatic logic [15:0] enc_k(int op, int rd, int k);
        return {op[4:0], rd[2:0], k[7:0]};
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic prog_clear();
        for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
    endtask

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
        m_cy = 0; m_eq = 0; m_pv = 0; m_pc = 0; m_pd = 0;
    endtask

    task automatic model_step();
        logic [15:0] w;
        logic [4:0]  op;
        logic [2:0]  rd, rr;
        logic [7:0]  k, a, b, res;
        logic [8:0]  s;
        bit          wr;
        w = prog[m_pc];
        op = w[15:11]; rd = w[10:8]; rr = w[7:5]; k = w[7:0];
        a = m_reg[rd]; b = m_reg[rr]; wr = 1; res = 0;
        m_pv = 0;
        case (op)
            5'd1:  res = dmem[k];
            5'd2:  res = k;
            5'd3:  res = b;
            5'd4:  begin s = {1'b0, a} + {1'b0, b};        res = s[7:0]; m_cy = s[8]; end
            5'd5:  begin s = {1'b0, a} + {1'b0, k};        res = s[7:0]; m_cy = s[8]; end
            5'd6:  begin s = {1'b0, a} + {1'b0, b} + m_cy; res = s[7:0]; m_cy = s[8]; end
            5'd7:  begin s = {1'b0, a} + {1'b0, k} + m_cy; res = s[7:0]; m_cy = s[8]; end
            5'd8:  res = a & b;
            5'd9:  res = a & k;
            5'd10: res = a | b;
            5'd11: res = a | k;
            5'd12: res = a ^ b;
            5'd13: res = ~a;
            5'd14: res = {a[6:0], a[7]};
            5'd15: begin m_eq = (a == k); wr = 0; end
            default: wr = 0;
        endcase
        if (wr) begin
            m_reg[rd] = res;
            if (rd == 3'd7) begin m_pv = 1; m_pd = res; end
        end
        if (op == 5'd16 && !m_eq) m_pc = k;
        else m_pc = m_pc + 8'd1;
    endtask

    task automatic run_prog(string tag, int ncyc);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R1", "reset imem_addr", imem_addr, 0);
        chk("R1", "reset pat_valid", pat_valid, 0);
        chk("R1", "reset pat_data", pat_data, 0);
        model_reset();
        rst = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            model_step();
            chk(tag, "imem_addr", imem_addr, m_pc);
            chk(tag, "pat_valid", pat_valid, m_pv);
            chk(tag, "pat_data", pat_data, m_pd);
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 256; i++) dmem[i] = 8'(i * 7 + 3);
        dmem[8'h10] = 8'h3C;

        // R1: registers and flags cleared by reset
        prog_clear();
        prog[0] = enc_r(3, 7, 3);
        prog[1] = enc_k(7, 7, 0);
        prog[2] = enc_k(16, 0, 6);
        prog[3] = enc_k(2, 7, 8'hBB);
        prog[6] = enc_k(2, 7, 8'h66);
        run_prog("R1", 8);

        // R2 / R3: loads and move
        prog_clear();
        prog[0] = enc_k(2, 1, 8'hA5);
        prog[1] = enc_k(1, 7, 8'h10);
        prog[2] = enc_r(3, 7, 1);
        prog[3] = enc_k(2, 2, 8'h5A);
        prog[4] = enc_r(3, 7, 2);
        prog[5] = enc_r(3, 7, 1);
        prog[6] = enc_k(1, 7, 8'hFE);
        run_prog("R2_R3", 10);

        // R4: carry out and carry in
        prog_clear();
        prog[0] = enc_k(2, 7, 8'hFF);
        prog[1] = enc_k(5, 7, 1);
        prog[2] = enc_k(7, 7, 0);
        prog[3] = enc_k(2, 2, 8'h80);
        prog[4] = enc_r(4, 2, 2);
        prog[5] = enc_r(6, 7, 2);
        prog[6] = enc_k(7, 7, 8'hFE);
        prog[7] = enc_k(7, 7, 0);
        run_prog("R4", 10);

        // R5: bitwise operations
        prog_clear();
        prog[0] = enc_k(2, 1, 8'hF0);
        prog[1] = enc_k(2, 7, 8'h3C);
        prog[2] = enc_r(8, 7, 1);
        prog[3] = enc_k(11, 7, 8'h03);
        prog[4] = enc_r(12, 7, 1);
        prog[5] = enc_k(9, 7, 8'h5A);
        prog[6] = enc_r(10, 7, 1);
        run_prog("R5", 9);

        // R6: invert and rotate, carry untouched
        prog_clear();
        prog[0] = enc_k(2, 3, 8'hFF);
        prog[1] = enc_k(5, 3, 1);
        prog[2] = enc_k(2, 7, 8'h81);
        prog[3] = enc_r(14, 7, 0);
        prog[4] = enc_r(13, 7, 0);
        prog[5] = enc_k(7, 7, 0);
        prog[6] = enc_r(14, 7, 0);
        run_prog("R6", 9);

        // R7 / R8: compare and loop
        prog_clear();
        prog[0] = enc_k(2, 1, 0);
        prog[1] = enc_k(5, 1, 1);
        prog[2] = enc_r(3, 7, 1);
        prog[3] = enc_k(15, 1, 4);
        prog[4] = enc_k(16, 0, 1);
        prog[5] = enc_k(2, 7, 8'hEE);
        prog[6] = enc_k(15, 7, 8'h11);
        prog[7] = enc_k(16, 0, 9);
        prog[8] = enc_k(2, 7, 8'h77);
        prog[9] = enc_r(3, 7, 1);
        run_prog("R7_R8", 30);

        // R9: undefined opcodes, counter wrap
        prog_clear();
        for (int i = 0; i < 15; i++) prog[i] = enc_k(17 + i, 7, 8'hC3);
        prog[15] = enc_k(2, 7, 8'h42);
        prog[254] = enc_k(2, 7, 8'h99);
        prog[255] = enc_k(0, 7, 8'hFF);
        run_prog("R9", 275);

        // R10: random programs, strobe and pattern on every cycle
        for (int t = 0; t < 20; t++) begin
            prog_clear();
            for (int i = 0; i < 256; i++) dmem[i] = 8'($urandom);
            for (int i = 0; i < 32; i++) begin
                int op, rd;
                op = $urandom_range(0, 31);
                rd = ($urandom_range(0, 1) == 1) ? 7 : $urandom_range(0, 7);
                if (op == 16) prog[i] = enc_k(op, rd, $urandom_range(0, 31));
                else prog[i] = enc_k(op, rd, $urandom_range(0, 255));
            end
            run_prog("R10", 300);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule